// File: doc/BRIEF.md
# PPU Bank Mapper with Per-Slot Nametable Select

This block is the picture-side address translator of a cartridge bank controller. The CPU programs it through two byte-wide registers: a control register and a data register. The control register holds a CHR layout mode bit and a pointer. The data register loads the bank register that the pointer names. Six bank registers decide which CHR memory page appears in each window of the PPU pattern space.

On every PPU access, the block looks only at PPU address bits 12, 11 and 10. From them it picks one bank register and drives CHR address lines 10 to 16 from it. PPU address bit 13 is never examined, so a nametable fetch in 0x2000–0x2FFF is decoded exactly like a pattern fetch in 0x0000–0x0FFF. The top bit of the selected bank register does not reach the CHR address. It drives a separate output wired to A10 of the console's nametable RAM, so each 1KB or 2KB nametable slot can be pointed at either of the two physical nametables. The conventional mirroring register is accepted on the bus and discarded.

The translation is purely combinational from the PPU address. Register loads take effect on the rising clock edge on which the CPU write strobe is high.

Top module: `ppu_bank_nt_map`

## Requirements
- R1: After synchronous reset, every bank register, the mode bit and the pointer are zero. With the mode bit clear, address 0x0000 then gives CHR page 0 with select 0, and address 0x0400 gives CHR page 1.
- R2: A write with `cpu_reg_sel` = 0 loads the control register. Data bit 7 is the layout mode bit C, and bits 2:0 are the pointer. Bit 6 and bits 5:3 have no effect on any output. A write with `cpu_reg_sel` = 1 loads the bank register that the pointer names.
- R3: In a 2KB window, `chr_bank_addr` equals bits 6:0 of the bank value with bit 0 replaced by PPU A10. With C clear, R0 serves 0x0000–0x07FF and R1 serves 0x0800–0x0FFF.
- R4: In a 1KB window, `chr_bank_addr` equals bits 6:0 of the bank value. With C clear, R2, R3, R4 and R5 serve 0x1000, 0x1400, 0x1800 and 0x1C00.
- R5: With C set, the 2KB and 1KB halves trade places. R2 to R5 then serve 0x0000, 0x0400, 0x0800 and 0x0C00, and R0 and R1 serve 0x1000–0x17FF and 0x1800–0x1FFF.
- R6: PPU A13 is ignored. An address with A13 set yields the same outputs as the same address with A13 clear.
- R7: With C set, the nametable slots at 0x2000, 0x2400, 0x2800 and 0x2C00 take `nt_page_sel` from bit 7 of R2, R3, R4 and R5. Bit 7 clear selects nametable 0 and bit 7 set selects nametable 1.
- R8: With C clear, the slots at 0x2000 and 0x2400 take `nt_page_sel` from bit 7 of R0, and the slots at 0x2800 and 0x2C00 take it from bit 7 of R1.
- R9: Writes with `cpu_reg_sel` = 2 (mirroring register) or 3 (unused) change no output.
- R10: Data writes while the pointer is 6 or 7 are accepted on the bus but change no output.
- R11: Bank bit 7 never appears on `chr_bank_addr`, which limits the CHR space to 128KB. A bank value of 0xFF gives `chr_bank_addr` = 0x7F with `nt_page_sel` = 1.
- R12: Registers change only on a clock edge where `cpu_we` is high. With `cpu_we` low, the outputs for a given address hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-side register clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe, sampled on the rising clock edge |
| cpu_reg_sel | input | 2 | Register target: 0 control, 1 bank data, 2 mirroring, 3 unused |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 14 | PPU address bus |
| chr_bank_addr | output | 7 | CHR memory address lines 10 to 16 |
| nt_page_sel | output | 1 | A10 of the nametable RAM: 0 selects nametable 0, 1 selects nametable 1 |

## Verification
The bench builds the block with the default bank width of 8 bits and a 3-bit pointer. With these values, bit 7 of each bank register is split off as the nametable select, and the pointer can name the two registers 6 and 7 that have no backing storage. Under these settings, bank values with bit 7 set and bit 7 clear are placed in different registers in both layout modes. This lets a single address walk separate the 2KB and 1KB windows, the A13 alias, and the two nametable slot groupings. Writes with the 0xFF pattern, writes through the pointer to registers 6 and 7, and writes to the mirroring and unused targets then show which bits and writes fail to reach the outputs.

// File: rtl/ppu_bank_nt_pkg.sv
package ppu_bank_nt_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_BANK   = 2'd1,
    REG_MIRROR = 2'd2,
    REG_SPARE  = 2'd3
  } cpu_reg_e;

  // bank registers that have storage; the pointer may name more
  localparam int NUM_CHR_BANKS = 6;

  // first 1KB register in the slot order
  localparam int FIRST_1K_BANK = 2;

  // PPU address bits that decode a slot
  localparam int PA_A10 = 10;
  localparam int PA_A11 = 11;
  localparam int PA_A12 = 12;

endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import ppu_bank_nt_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   we,
  input  logic [1:0]                             reg_sel,
  input  logic [BANK_W-1:0]                      wdata,
  output logic                                   mode_c,
  output logic [SEL_W-1:0]                       ptr,
  output logic [NUM_CHR_BANKS-1:0][BANK_W-1:0]   banks
);

  logic ctrl_wr;
  logic bank_wr;

  assign ctrl_wr = we && (reg_sel == REG_CTRL);
  assign bank_wr = we && (reg_sel == REG_BANK);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_c <= 1'b0;
      ptr    <= '0;
    end else if (ctrl_wr) begin
      mode_c <= wdata[BANK_W-1];
      ptr    <= wdata[SEL_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CHR_BANKS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        banks[g] <= '0;
      end else if (bank_wr && (ptr == SEL_W'(g))) begin
        banks[g] <= wdata;
      end
    end
  end

endmodule

// File: rtl/ppu_slot_decode.sv
module ppu_slot_decode
  import ppu_bank_nt_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             mode_c,
  input  logic             a12,
  input  logic             a11,
  input  logic             a10,
  output logic [SEL_W-1:0] slot_bank,
  output logic             is_2k
);

  logic half_1k;

  // the mode bit swaps the 2KB and 1KB halves
  assign half_1k = a12 ^ mode_c;

  always_comb begin
    if (half_1k) begin
      is_2k     = 1'b0;
      slot_bank = SEL_W'(FIRST_1K_BANK) + SEL_W'({a11, a10});
    end else begin
      is_2k     = 1'b1;
      slot_bank = SEL_W'(a11);
    end
  end

endmodule

// File: rtl/chr_nt_out_mux.sv
module chr_nt_out_mux
  import ppu_bank_nt_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int SEL_W  = 3,
  localparam int CHR_W = BANK_W - 1
) (
  input  logic [NUM_CHR_BANKS-1:0][BANK_W-1:0] banks,
  input  logic [SEL_W-1:0]                     slot_bank,
  input  logic                                 is_2k,
  input  logic                                 a10,
  output logic [CHR_W-1:0]                     chr_out,
  output logic                                 nt_sel
);

  logic [BANK_W-1:0] chosen;

  always_comb begin
    chosen = '0;
    for (int k = 0; k < NUM_CHR_BANKS; k++) begin
      if (slot_bank == SEL_W'(k)) chosen = banks[k];
    end
  end

  always_comb begin
    if (is_2k) chr_out = {chosen[CHR_W-1:1], a10};
    else       chr_out = chosen[CHR_W-1:0];
    nt_sel = chosen[BANK_W-1];
  end

endmodule

// File: rtl/ppu_bank_nt_map.sv
module ppu_bank_nt_map
  import ppu_bank_nt_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int SEL_W  = 3,
  parameter int PPU_AW = 14,
  localparam int CHR_W = BANK_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_reg_sel,
  input  logic [BANK_W-1:0] cpu_wdata,
  input  logic [PPU_AW-1:0] ppu_addr,
  output logic [CHR_W-1:0]  chr_bank_addr,
  output logic              nt_page_sel
);

  logic                               chr_mode_q;
  logic [SEL_W-1:0]                   sel_idx_q;
  logic [NUM_CHR_BANKS-1:0][BANK_W-1:0] bank_q;
  logic [SEL_W-1:0]                   slot_bank;
  logic                               slot_is_2k;

  // A13 and the in-page bits play no part in translation
  logic unused_addr_bits;
  assign unused_addr_bits = ^{ppu_addr[PPU_AW-1:PA_A12+1], ppu_addr[PA_A10-1:0]};

  chr_bank_regs #(.BANK_W(BANK_W), .SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (cpu_we),
    .reg_sel (cpu_reg_sel),
    .wdata   (cpu_wdata),
    .mode_c  (chr_mode_q),
    .ptr     (sel_idx_q),
    .banks   (bank_q)
  );

  ppu_slot_decode #(.SEL_W(SEL_W)) u_dec (
    .mode_c    (chr_mode_q),
    .a12       (ppu_addr[PA_A12]),
    .a11       (ppu_addr[PA_A11]),
    .a10       (ppu_addr[PA_A10]),
    .slot_bank (slot_bank),
    .is_2k     (slot_is_2k)
  );

  chr_nt_out_mux #(.BANK_W(BANK_W), .SEL_W(SEL_W)) u_mux (
    .banks     (bank_q),
    .slot_bank (slot_bank),
    .is_2k     (slot_is_2k),
    .a10       (ppu_addr[PA_A10]),
    .chr_out   (chr_bank_addr),
    .nt_sel    (nt_page_sel)
  );

endmodule

// File: rtl/ppu_bank_nt_map_chk.sv
module ppu_bank_nt_map_chk #(
  parameter int BANK_W = 8,
  parameter int SEL_W  = 3,
  parameter int PPU_AW = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_we,
  input logic [1:0]        cpu_reg_sel,
  input logic [PPU_AW-1:0] ppu_addr,
  input logic [BANK_W-2:0] chr_bank_addr,
  input logic              nt_page_sel,
  input logic              mode_c,
  input logic [SEL_W-1:0]  sel_idx
);

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && ppu_addr[12:10] == 3'b000) |-> (chr_bank_addr == '0 && !nt_page_sel));

  // R3
  two_k_low_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (ppu_addr[12] == mode_c) |-> (chr_bank_addr[0] == ppu_addr[10]));

  // R9
  mirror_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_reg_sel[1]) |=>
      (!$stable(ppu_addr) || ($stable(chr_bank_addr) && $stable(nt_page_sel))));

  // R10
  high_index_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_reg_sel == 2'd1 && sel_idx >= SEL_W'(6)) |=>
      (!$stable(ppu_addr) || ($stable(chr_bank_addr) && $stable(nt_page_sel))));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_we |=>
      (!$stable(ppu_addr) || ($stable(chr_bank_addr) && $stable(nt_page_sel))));

endmodule

bind ppu_bank_nt_map ppu_bank_nt_map_chk #(
  .BANK_W(BANK_W), .SEL_W(SEL_W), .PPU_AW(PPU_AW)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cpu_we        (cpu_we),
  .cpu_reg_sel   (cpu_reg_sel),
  .ppu_addr      (ppu_addr),
  .chr_bank_addr (chr_bank_addr),
  .nt_page_sel   (nt_page_sel),
  .mode_c        (chr_mode_q),
  .sel_idx       (sel_idx_q)
);

// File: tb/tb_ppu_bank_nt_map.sv
`timescale 1ns/1ps
module tb_ppu_bank_nt_map;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_reg_sel = 2'd0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [13:0] ppu_addr = 14'h0000;
  logic [6:0]  chr_bank_addr;
  logic        nt_page_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  ppu_bank_nt_map #(.BANK_W(8), .SEL_W(3), .PPU_AW(14)) dut (
    .clk           (clk),
    .rst           (rst),
    .cpu_we        (cpu_we),
    .cpu_reg_sel   (cpu_reg_sel),
    .cpu_wdata     (cpu_wdata),
    .ppu_addr      (ppu_addr),
    .chr_bank_addr (chr_bank_addr),
    .nt_page_sel   (nt_page_sel)
  );

  // {is_check, sel, data, addr, exp_chr, exp_nt, req}
  localparam int NV = 61;
  localparam logic [36:0] VEC [NV] = '{
    // R2 load banks through pointer, mode clear
    {1'b0,2'd0,8'h00,14'h0000,7'h00,1'b0,4'd2}, {1'b0,2'd1,8'h2A,14'h0000,7'h00,1'b0,4'd2},
    {1'b0,2'd0,8'h01,14'h0000,7'h00,1'b0,4'd2}, {1'b0,2'd1,8'h95,14'h0000,7'h00,1'b0,4'd2},
    {1'b0,2'd0,8'h02,14'h0000,7'h00,1'b0,4'd2}, {1'b0,2'd1,8'h83,14'h0000,7'h00,1'b0,4'd2},
    {1'b0,2'd0,8'h03,14'h0000,7'h00,1'b0,4'd2}, {1'b0,2'd1,8'h14,14'h0000,7'h00,1'b0,4'd2},
    {1'b0,2'd0,8'h04,14'h0000,7'h00,1'b0,4'd2}, {1'b0,2'd1,8'hC5,14'h0000,7'h00,1'b0,4'd2},
    {1'b0,2'd0,8'h05,14'h0000,7'h00,1'b0,4'd2}, {1'b0,2'd1,8'h66,14'h0000,7'h00,1'b0,4'd2},
    {1'b0,2'd0,8'h06,14'h0000,7'h00,1'b0,4'd2}, {1'b0,2'd1,8'h7F,14'h0000,7'h00,1'b0,4'd2},
    {1'b0,2'd0,8'h07,14'h0000,7'h00,1'b0,4'd2}, {1'b0,2'd1,8'h7F,14'h0000,7'h00,1'b0,4'd2},
    // R3 2KB windows, mode clear
    {1'b1,2'd0,8'h00,14'h0000,7'h2A,1'b0,4'd3}, {1'b1,2'd0,8'h00,14'h0400,7'h2B,1'b0,4'd3},
    {1'b1,2'd0,8'h00,14'h0800,7'h14,1'b1,4'd3}, {1'b1,2'd0,8'h00,14'h0C00,7'h15,1'b1,4'd3},
    // R4 1KB windows, mode clear
    {1'b1,2'd0,8'h00,14'h1000,7'h03,1'b1,4'd4}, {1'b1,2'd0,8'h00,14'h1400,7'h14,1'b0,4'd4},
    {1'b1,2'd0,8'h00,14'h1800,7'h45,1'b1,4'd4}, {1'b1,2'd0,8'h00,14'h1C00,7'h66,1'b0,4'd4},
    // R8 nametable slots, mode clear
    {1'b1,2'd0,8'h00,14'h2000,7'h2A,1'b0,4'd8}, {1'b1,2'd0,8'h00,14'h2400,7'h2B,1'b0,4'd8},
    {1'b1,2'd0,8'h00,14'h2800,7'h14,1'b1,4'd8}, {1'b1,2'd0,8'h00,14'h2C00,7'h15,1'b1,4'd8},
    // R6 A13 alias inside a slot
    {1'b1,2'd0,8'h00,14'h23FF,7'h2A,1'b0,4'd6},
    // R2 set mode bit
    {1'b0,2'd0,8'h80,14'h0000,7'h00,1'b0,4'd2},
    // R5 halves swapped
    {1'b1,2'd0,8'h00,14'h0000,7'h03,1'b1,4'd5}, {1'b1,2'd0,8'h00,14'h0400,7'h14,1'b0,4'd5},
    {1'b1,2'd0,8'h00,14'h0800,7'h45,1'b1,4'd5}, {1'b1,2'd0,8'h00,14'h0C00,7'h66,1'b0,4'd5},
    {1'b1,2'd0,8'h00,14'h1000,7'h2A,1'b0,4'd5}, {1'b1,2'd0,8'h00,14'h1400,7'h2B,1'b0,4'd5},
    {1'b1,2'd0,8'h00,14'h1800,7'h14,1'b1,4'd5}, {1'b1,2'd0,8'h00,14'h1C00,7'h15,1'b1,4'd5},
    // R7 nametable slots, mode set
    {1'b1,2'd0,8'h00,14'h2000,7'h03,1'b1,4'd7}, {1'b1,2'd0,8'h00,14'h2400,7'h14,1'b0,4'd7},
    {1'b1,2'd0,8'h00,14'h2800,7'h45,1'b1,4'd7}, {1'b1,2'd0,8'h00,14'h2C00,7'h66,1'b0,4'd7},
    // R6 A13 set with A12..A10 all set
    {1'b1,2'd0,8'h00,14'h3C00,7'h15,1'b1,4'd6},
    // R9 mirroring and unused targets
    {1'b0,2'd2,8'h01,14'h0000,7'h00,1'b0,4'd9}, {1'b0,2'd3,8'hFF,14'h0000,7'h00,1'b0,4'd9},
    {1'b1,2'd0,8'h00,14'h2400,7'h14,1'b0,4'd9}, {1'b1,2'd0,8'h00,14'h2000,7'h03,1'b1,4'd9},
    // R10 writes through pointer 6 and 7
    {1'b0,2'd0,8'h86,14'h0000,7'h00,1'b0,4'd10}, {1'b0,2'd1,8'hFF,14'h0000,7'h00,1'b0,4'd10},
    {1'b0,2'd0,8'h87,14'h0000,7'h00,1'b0,4'd10}, {1'b0,2'd1,8'h00,14'h0000,7'h00,1'b0,4'd10},
    {1'b1,2'd0,8'h00,14'h0000,7'h03,1'b1,4'd10}, {1'b1,2'd0,8'h00,14'h1C00,7'h15,1'b1,4'd10},
    // R2 bit 6 ignored
    {1'b0,2'd0,8'hC2,14'h0000,7'h00,1'b0,4'd2},  {1'b1,2'd0,8'h00,14'h0000,7'h03,1'b1,4'd2},
    // R11 bit 7 kept off the CHR lines
    {1'b0,2'd1,8'hFF,14'h0000,7'h00,1'b0,4'd11}, {1'b1,2'd0,8'h00,14'h0000,7'h7F,1'b1,4'd11},
    {1'b0,2'd0,8'h42,14'h0000,7'h00,1'b0,4'd2},  {1'b1,2'd0,8'h00,14'h1000,7'h7F,1'b1,4'd2},
    {1'b0,2'd1,8'h7F,14'h0000,7'h00,1'b0,4'd11}, {1'b1,2'd0,8'h00,14'h1000,7'h7F,1'b0,4'd11}
  };

  task automatic cpu_write(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    cpu_reg_sel = sel;
    cpu_wdata   = data;
    cpu_we      = 1'b1;
    @(negedge clk);
    cpu_we      = 1'b0;
  endtask

  task automatic probe(input logic [13:0] addr, input logic [6:0] exp_chr,
                       input logic exp_nt, input int req);
    @(negedge clk);
    ppu_addr = addr;
    #1;
    n_tests++;
    if (chr_bank_addr !== exp_chr || nt_page_sel !== exp_nt) begin
      n_fail++;
      $display("FAIL R%0d addr=%h chr=%h/%b expected chr=%h/%b",
               req, addr, chr_bank_addr, nt_page_sel, exp_chr, exp_nt);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      automatic logic [36:0] v = VEC[i];
      if (v[36]) probe(v[25:12], v[11:5], v[4], int'(v[3:0]));
      else       cpu_write(v[35:34], v[33:26]);
    end

    // R12 data presented with strobe low leaves R2 untouched
    @(negedge clk);
    cpu_reg_sel = 2'd1;
    cpu_wdata   = 8'h00;
    cpu_we      = 1'b0;
    repeat (2) @(negedge clk);
    probe(14'h1000, 7'h7F, 1'b0, 12);

    // R1 reset clears everything
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    probe(14'h0000, 7'h00, 1'b0, 1);
    probe(14'h0400, 7'h01, 1'b0, 1);
    probe(14'h1000, 7'h00, 1'b0, 1);
    probe(14'h2C00, 7'h01, 1'b0, 1);
    // R1 pointer reset to 0: data write lands in R0
    cpu_write(2'd1, 8'h80);
    probe(14'h2000, 7'h00, 1'b1, 1);
    probe(14'h2400, 7'h01, 1'b1, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule